// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests from peripherals and steers each one onto one of six CPU interrupt lines, numbered IP2 to IP7. Each raw request passes through a two-flop synchroniser into a status register. The status is ANDed with a per-source enable mask, and the result is the pending vector. For every CPU line, the block ORs together the pending sources routed to that line and registers the result. A software handler acknowledges a level source by clearing its mask bit.

Each line also reports the number of its highest-priority pending source, so a dispatcher can find the requester without scanning the status register. The register port is a plain single-cycle bus. A write takes effect on the clock edge at which `bus_sel_i` and `bus_wr_i` are high. Reads are combinational. The port has no handshake and applies no back-pressure, so every access completes in the cycle it is presented.

Some source numbers have fixed roles, and the priority order depends on them:

| Source | Number |
|---|---|
| primary UART | 31 |
| secondary UART | 30 |
| primary timer | 29 |
| secondary timer | 28 |
| bus timeouts | 27, 26, 25 |
| network controller | 24 |
| GPIO banks | 23 |
| switch core | 20 |

Top module: `irq_router_top`

## Requirements
- R1: After reset, the enable mask and all routing fields read zero, `pending_o` is zero, every `cpu_irq_o` bit is low and every `irq_idx_o` field is zero.
- R2: The enable mask sits at byte offset 0x00 and reads back what was written. Bit n set enables source n.
- R3: The status register sits at offset 0x04. It shows `src_i` as sampled two clock edges earlier: a change is invisible after one edge and visible after two. Writes to 0x04 change neither the mask nor any routing field.
- R4: `pending_o` always equals the mask ANDed with the status register.
- R5: The four routing registers sit at offsets 0x08, 0x0C, 0x10 and 0x14.
  - They hold sources 31..24, 23..16, 15..8 and 7..0 respectively.
  - Source s uses bits [4*(s mod 8)+3 : 4*(s mod 8)].
  - A field value of 1 to 6 selects IP2 to IP7, which are `cpu_irq_o` bits 0 to 5.
  - A field value of 0 or 7 to 15 leaves the source unrouted.
  - Every register reads back as written.
- R6: `cpu_irq_o[l]` is the OR of all pending sources routed to line l. It is registered, so it follows `pending_o` one clock edge later, and several sources may share a line.
- R7: A line drops one edge after the write that masks its last pending source. When that source input instead goes low, the line drops three edges later: two for the synchroniser and one for the line register.
- R8: `irq_idx_o[5l+4:5l]` gives the winning pending source on line l, registered together with the line, and reads zero when the line is idle. The winner is the source with the lowest rank:
  - 31 has rank 0.
  - 29 has rank 1.
  - 28 has rank 2.
  - 30 has rank 3.
  - Any other source s has rank 31-s.
  - As a result, the network controller (24) beats GPIO (23), and the secondary timer (28) beats the secondary UART (30).
- R9: Offsets above 0x14, or with address bits [1:0] not zero, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Raw level interrupt requests |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| pending_o | output | 32 | Masked pending vector |
| cpu_irq_o | output | 6 | CPU lines IP2 (bit 0) to IP7 (bit 5) |
| irq_idx_o | output | 30 | Winning source per line, 5 bits per line |

## Verification
The bench targets the following corner cases:
- **Synchroniser latency.** A design with one flop too few shows the status change after a single edge.
- **Masking as acknowledge.** A line still high two edges after its mask write exposes an extra pipeline stage.
- **Priority swap on IP2.** A plain highest-number encoder would report 30 instead of 28.
- **Priority on IP5.** A lowest-number encoder would report 23 instead of 24.
- **Unrouted field codes 7 to 15.** A design that aliases these codes onto real lines raises a spurious line.
- **Routing register order.** Randomly mixed routes and masks catch swapped register order or field placement.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC  = 32;
  localparam int NLINE = 6;
  localparam int FW    = 4;
  localparam int IW    = $clog2(NSRC);
  localparam int NREG  = NSRC * FW / 32;
  localparam int AW    = 5;

  localparam logic [IW-1:0] SRC_UART1  = IW'(30);
  localparam logic [IW-1:0] SRC_TIMER0 = IW'(29);
  localparam logic [IW-1:0] SRC_TIMER1 = IW'(28);

  // Source found at scan rank k (rank 0 is the strongest claim on a line).
  function automatic logic [IW-1:0] scan_src(input int k);
    logic [IW-1:0] s;
    case (k)
      1:       s = SRC_TIMER0;
      2:       s = SRC_TIMER1;
      3:       s = SRC_UART1;
      default: s = IW'(NSRC - 1 - k);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= raw_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [NSRC-1:0]   status_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC*FW-1:0] route_o
);
  localparam int WORD_MASK  = 0;
  localparam int WORD_STAT  = 1;
  localparam int WORD_ROUTE = 2;

  logic [NSRC-1:0]    mask_q;
  logic [NSRC*FW-1:0] route_q;
  logic [AW-3:0]      word;
  logic               aligned;

  assign word    = bus_addr_i[AW-1:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (bus_sel_i && bus_wr_i && aligned) begin
      if (int'(word) == WORD_MASK) mask_q <= bus_wdata_i[NSRC-1:0];
      for (int r = 0; r < NREG; r++) begin
        if (int'(word) == WORD_ROUTE + r)
          route_q[(NREG-1-r)*32 +: 32] <= bus_wdata_i;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (aligned) begin
      if (int'(word) == WORD_MASK) bus_rdata_o = 32'(mask_q);
      if (int'(word) == WORD_STAT) bus_rdata_o = 32'(status_i);
      for (int r = 0; r < NREG; r++) begin
        if (int'(word) == WORD_ROUTE + r)
          bus_rdata_o = route_q[(NREG-1-r)*32 +: 32];
      end
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;

  p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i && bus_addr_i == AW'(0)) |=> (mask_q == $past(bus_wdata_i[NSRC-1:0])))
    else $error("mask write not taken");

  p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i && bus_addr_i == AW'(4)) |=> ($stable(mask_q) && $stable(route_q)))
    else $error("status write altered state");
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_router_pkg::*;
#(
  parameter int LINE_CODE = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC*FW-1:0] route_i,
  output logic               irq_o,
  output logic [IW-1:0]      idx_o
);
  logic [NSRC-1:0] hits;
  logic [IW-1:0]   win;

  always_comb begin
    for (int s = 0; s < NSRC; s++)
      hits[s] = pend_i[s] && (route_i[s*FW +: FW] == FW'(LINE_CODE));
  end

  // Walk from weakest to strongest rank; the last hit seen wins.
  always_comb begin
    win = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (hits[scan_src(k)]) win = scan_src(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      idx_o <= '0;
    end else begin
      irq_o <= |hits;
      idx_o <= win;
    end
  end

  p_idx_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((($past(hits) >> idx_o) & NSRC'(1)) != '0))
    else $error("reported index was not pending on this line");
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [4:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [31:0]       pending_o,
  output logic [5:0]        cpu_irq_o,
  output logic [29:0]       irq_idx_o
);
  logic [NSRC-1:0]    status;
  logic [NSRC-1:0]    mask;
  logic [NSRC*FW-1:0] route;

  irq_sync #(.W(NSRC)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(src_i), .sync_o(status)
  );

  irq_regs regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .status_i(status), .bus_rdata_o(bus_rdata_o),
    .mask_o(mask), .route_o(route)
  );

  assign pending_o = mask & status;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    irq_line #(.LINE_CODE(l + 1)) line_i (
      .clk(clk), .rst_n(rst_n), .pend_i(pending_o), .route_i(route),
      .irq_o(cpu_irq_o[l]), .idx_o(irq_idx_o[l*IW +: IW])
    );
  end

  p_idle_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == '0) |=> (cpu_irq_o == '0))
    else $error("line high with nothing pending");

  p_line_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_o != '0) |-> ($past(pending_o) != '0))
    else $error("line raised without pending source");
endmodule

// File: tb/irq_router_top_tb_top.sv
module irq_router_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pending;
  logic [5:0]  cpu_irq;
  logic [29:0] idx;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_mask;
  logic [31:0] m_route [4];

  always #5 clk = ~clk;

  irq_router_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pending_o(pending), .cpu_irq_o(cpu_irq), .irq_idx_o(idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int rank(input int s);
    if (s == 31) return 0;
    if (s == 29) return 1;
    if (s == 28) return 2;
    if (s == 30) return 3;
    return 31 - s;
  endfunction

  function automatic logic [3:0] field(input int s);
    return m_route[3 - s / 8][(s % 8) * 4 +: 4];
  endfunction

  // Expected lines and indices from the model state and a given pending vector.
  task automatic model(input logic [31:0] pend, output logic [5:0] lines, output logic [29:0] ix);
    lines = '0; ix = '0;
    for (int l = 0; l < 6; l++) begin
      int best = 99;
      for (int s = 0; s < 32; s++) begin
        if (pend[s] && field(s) == 4'(l + 1) && rank(s) < best) begin
          best = rank(s);
          lines[l] = 1'b1;
          ix[l*5 +: 5] = 5'(s);
        end
      end
    end
  endtask

  task automatic check_all(input string req);
    logic [5:0] el; logic [29:0] ei;
    model(m_mask & src, el, ei);
    check(req, pending, m_mask & src);
    check(req, 32'(cpu_irq), 32'(el));
    check(req, 32'(idx), 32'(ei));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    void'($urandom(32'd1234));
    m_mask = '0;
    for (int r = 0; r < 4; r++) m_route[r] = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    check("R1 pending", pending, '0);
    check("R1 lines", 32'(cpu_irq), '0);
    check("R1 idx", 32'(idx), '0);
    rd_reg(5'h00, d); check("R1 mask", d, '0);
    for (int r = 0; r < 4; r++) begin
      rd_reg(5'(8 + 4 * r), d); check("R1 route", d, '0);
    end

    // R2 mask write and readback
    wr_reg(5'h00, 32'hA5A5_0F0F); rd_reg(5'h00, d); check("R2 mask rb", d, 32'hA5A5_0F0F);
    wr_reg(5'h00, '0); m_mask = '0;

    // R3 two-edge synchroniser latency
    src = 32'h8000_0001;
    wait_n(1); rd_reg(5'h04, d); check("R3 one edge", d, '0);
    wait_n(1); rd_reg(5'h04, d); check("R3 two edges", d, 32'h8000_0001);
    wr_reg(5'h04, 32'hFFFF_FFFF);
    rd_reg(5'h00, d); check("R3 mask untouched", d, '0);
    rd_reg(5'h08, d); check("R3 route untouched", d, '0);
    check("R3 no line", 32'(cpu_irq), '0);

    // R5 routing layout with the default scheme
    m_route[0] = 32'h2151_1114; m_route[1] = 32'h4003_0000;
    wr_reg(5'h08, m_route[0]); wr_reg(5'h0C, m_route[1]);
    rd_reg(5'h08, d); check("R5 irr0 rb", d, m_route[0]);
    rd_reg(5'h0C, d); check("R5 irr1 rb", d, m_route[1]);

    // R6 only primary UART and primary timer enabled
    src = 32'hF990_0000;
    m_mask = 32'hA000_0000; wr_reg(5'h00, m_mask);
    wait_n(3);
    check_all("R6 init mask");
    check("R6 lines IP3 IP6", 32'(cpu_irq), 32'h12);
    check("R4 pending", pending, 32'hA000_0000);

    // R8 priority on shared lines
    m_mask = 32'hFFFF_FFFF; wr_reg(5'h00, m_mask); wait_n(1);
    check("R8 IP2 secondary timer", 32'(idx[4:0]), 32'd28);
    check("R8 IP5 network", 32'(idx[19:15]), 32'd24);
    check_all("R8 all");
    src[28] = 1'b0; wait_n(3);
    check("R8 IP2 secondary uart next", 32'(idx[4:0]), 32'd30);

    // R7 masking as acknowledge
    m_mask = 32'hFFFF_FFFF & ~32'h0100_0000 & ~32'h0080_0000;
    wr_reg(5'h00, m_mask);
    check("R7 line held one edge", 32'(cpu_irq[3]), 32'd1);
    wait_n(1);
    check("R7 line dropped", 32'(cpu_irq[3]), 32'd0);
    src[31] = 1'b0;
    wait_n(2); check("R7 source low still high", 32'(cpu_irq[1]), 32'd1);
    wait_n(1); check("R7 source low dropped", 32'(cpu_irq[1]), 32'd0);

    // R5 codes 7..15 leave a source unrouted
    m_route[3] = 32'h0000_00F9; wr_reg(5'h14, m_route[3]);
    src = 32'h0000_0003; m_mask = 32'h0000_0003; wr_reg(5'h00, m_mask);
    wait_n(3);
    check("R5 unrouted", 32'(cpu_irq), '0);
    check("R4 pending unrouted", pending, 32'h3);

    // R9 unmapped and misaligned accesses
    wr_reg(5'h18, 32'hFFFF_FFFF); rd_reg(5'h18, d); check("R9 unmapped read", d, '0);
    wr_reg(5'h01, 32'h1234_5678); rd_reg(5'h00, d); check("R9 misaligned write", d, m_mask);
    rd_reg(5'h09, d); check("R9 misaligned read", d, '0);

    // R4 R6 R8 random mix
    for (int it = 0; it < 300; it++) begin
      src = $urandom;
      m_mask = $urandom;
      for (int r = 0; r < 4; r++) begin
        logic [31:0] v = '0;
        for (int j = 0; j < 8; j++) v[j*4 +: 4] = 4'($urandom_range(0, (it % 3 == 0) ? 15 : 6));
        m_route[r] = v;
        wr_reg(5'(8 + 4 * r), v);
      end
      wr_reg(5'h00, m_mask);
      wait_n(1);
      check_all("R4 R6 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule